// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block sits behind a simple bus slave and gives a host indirect reach into two target spaces through a pointer register and a four-byte data window. The host first writes a pointer value into the index register. Accesses that later land on the window are steered by that pointer. With pointer bit 31 set, they reach linear video memory. With bit 31 clear and the pointer above the window, they reach the block's own register space. Every other address in the register space is passed straight through to the register port.

The block turns byte and halfword accesses into 32-bit register operations. For a read it picks out the addressed bytes. For a write it merges the new bytes into the current register word. Memory accesses are checked against the configured memory size. A pointer that would steer a window access back into the window itself is refused with an error pulse.

Control is a three-state machine.

- ST_IDLE decodes the request.
- ST_MEMACC performs one memory access.
- ST_REGACC performs one register access.

The transitions are:

- ST_IDLE goes to ST_MEMACC on an in-range window memory access.
- ST_IDLE goes to ST_REGACC on a forwarded window access or a direct register access.
- ST_IDLE stays in ST_IDLE on an index access, a refused access, a dropped access, or no request.
- ST_MEMACC and ST_REGACC always return to ST_IDLE.

Top module: `ixwin_bridge`

## Requirements
- R1: A write to the index register (host address 0) stores the write data with bits 1:0 cleared, whatever the access size. A read of the index register returns the full 32-bit stored value.
- R2: Window accesses use host addresses 4 to 7, and the window offset is `h_addr[1:0]`. For a forwarded register access, the offset is added to the pointer. For a memory access, the offset is ignored.
- R3: When pointer bit 31 is set, a window access goes to memory at byte address `pointer[30:0]`. The data is little-endian and starts at byte lane 0, so a byte uses bits 7:0 with `mem_be`=0001, a halfword uses bits 15:0 with `mem_be`=0011, and a word uses `mem_be`=1111.
- R4: A memory access is performed only if `pointer[30:0]` <= MEM_BYTES minus the access size in bytes. Otherwise it completes with read data 0, no error and no memory request.
- R5: When pointer bit 31 is clear and the pointer is greater than 7, a window access goes to the register at pointer plus offset, truncated to the low REG_AW bits.
- R6: When pointer bit 31 is clear and the pointer is 7 or less, a window access is refused. `h_err` pulses for that cycle, the read data is 0, and no target is touched.
- R7: Size encoding on `h_size` is 0 for a byte, 1 for a halfword, and 2 or 3 for a word. A sub-word register read returns the value `(word >> 8*lane) & sizemask`. A sub-word register write replaces only the bits `(sizemask << 8*lane)`, truncated to 32 bits, and keeps all other bits.
- R8: A word-sized register write at lane 0 writes the host data unchanged.
- R9: Index, refused and dropped accesses raise `h_ready` in the request cycle. Memory and register accesses raise `h_ready` in the following cycle, when the target port is driven.
- R10: A host access to any address other than 0 and 4 to 7 goes to the register port at that address, with the lane handling of R7.
- R11: After reset the pointer is 0, no port request is active and `h_ready` is low. As a consequence, a window access straight after reset is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host request, held until `h_ready` |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | REG_AW | Host byte address in register space |
| h_size | input | 2 | Access size (0 byte, 1 half, 2/3 word) |
| h_wdata | input | 32 | Host write data, right-aligned |
| h_rdata | output | 32 | Host read data, valid with `h_ready` |
| h_ready | output | 1 | Access completes this cycle |
| h_err | output | 1 | One-cycle pulse on a refused window access |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | log2(MEM_BYTES) | Memory byte address (word aligned) |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read word, same cycle |
| reg_req | output | 1 | Register port strobe |
| reg_we | output | 1 | Register write enable |
| reg_addr | output | REG_AW | Register word address (bits 1:0 zero) |
| reg_wdata | output | 32 | Merged register write word |
| reg_rdata | input | 32 | Register read word, same cycle |

## Verification
Some properties are checked on every cycle by assertions:

- The memory port is never driven out of bounds.
- An error cycle always returns zero and touches no port.
- A port access always ends after one cycle.
- A byte write keeps the unaddressed register bits, and a word write at lane 0 passes the data through.
- A stored pointer has clear low bits.

Other behaviour only shows in the bench's scenarios. This covers the pointer decoding at its boundaries: pointer 4 against 8, and the last legal memory word against the first illegal one. It also covers the offset arithmetic, the little-endian lane placement, and the fact that refused or dropped writes leave both storage arrays unchanged.

// File: rtl/ixwin_pkg.sv
package ixwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEMACC,
        ST_REGACC
    } state_e;

    typedef enum logic [2:0] {
        CL_INDEX,
        CL_DIRECT,
        CL_WIN_MEM,
        CL_WIN_REG,
        CL_REFUSE,
        CL_DROP
    } cls_e;

    // number of bytes moved by a given size code
    function automatic logic [2:0] szb(input logic [1:0] sz);
        case (sz)
            2'd0:    szb = 3'd1;
            2'd1:    szb = 3'd2;
            default: szb = 3'd4;
        endcase
    endfunction

    // right-aligned data mask for a given size code
    function automatic logic [31:0] szm(input logic [1:0] sz);
        case (sz)
            2'd0:    szm = 32'h0000_00FF;
            2'd1:    szm = 32'h0000_FFFF;
            default: szm = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/ixwin_decode.sv
module ixwin_decode
    import ixwin_pkg::*;
#(
    parameter int REG_AW    = 14,
    parameter int MEM_BYTES = 4096,
    parameter int IDX_ADDR  = 0,
    parameter int WIN_ADDR  = 4
) (
    input  logic [REG_AW-1:0]          h_addr,
    input  logic [1:0]                 h_size,
    input  logic [31:0]                idx_q,
    output cls_e                       cls,
    output logic [REG_AW-3:0]          tgt_word,
    output logic [1:0]                 lane,
    output logic [$clog2(MEM_BYTES)-1:0] mem_off
);
    localparam int MEM_AW = $clog2(MEM_BYTES);
    localparam logic [REG_AW-1:0] IDX_A    = REG_AW'(IDX_ADDR);
    localparam logic [REG_AW-1:0] WIN_A    = REG_AW'(WIN_ADDR);
    localparam logic [31:0]       WIN_LAST = 32'(WIN_ADDR + 3);

    logic [REG_AW-1:0] fwd_sum;
    logic [31:0]       mem_limit;

    always_comb begin
        fwd_sum   = idx_q[REG_AW-1:0] + REG_AW'(h_addr[1:0]);
        mem_limit = 32'(MEM_BYTES) - 32'(szb(h_size));
        cls       = CL_DIRECT;
        tgt_word  = h_addr[REG_AW-1:2];
        lane      = h_addr[1:0];
        mem_off   = idx_q[MEM_AW-1:0];
        if (h_addr == IDX_A) begin
            cls = CL_INDEX;
        end else if (h_addr[REG_AW-1:2] == WIN_A[REG_AW-1:2]) begin
            if (idx_q[31]) begin
                // memory path: offset is not applied, data starts at lane 0
                lane = 2'd0;
                cls  = ({1'b0, idx_q[30:0]} <= mem_limit) ? CL_WIN_MEM : CL_DROP;
            end else if (idx_q > WIN_LAST) begin
                cls      = CL_WIN_REG;
                tgt_word = fwd_sum[REG_AW-1:2];
                lane     = fwd_sum[1:0];
            end else begin
                cls = CL_REFUSE;
            end
        end
    end

endmodule

// File: rtl/ixwin_lanes.sv
module ixwin_lanes
    import ixwin_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    input  logic [31:0] word_in,
    input  logic [31:0] wdata,
    output logic [31:0] rd_val,
    output logic [31:0] wr_word
);
    logic [4:0]  shamt;
    logic [31:0] fmask;

    always_comb begin
        shamt   = {lane, 3'b000};
        fmask   = szm(size) << shamt;
        rd_val  = (word_in >> shamt) & szm(size);
        wr_word = (word_in & ~fmask) | ((wdata << shamt) & fmask);
    end

endmodule

// File: rtl/ixwin_bridge.sv
module ixwin_bridge
    import ixwin_pkg::*;
#(
    parameter int REG_AW    = 14,
    parameter int MEM_BYTES = 4096,
    parameter int IDX_ADDR  = 0,
    parameter int WIN_ADDR  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          h_valid,
    input  logic                          h_write,
    input  logic [REG_AW-1:0]             h_addr,
    input  logic [1:0]                    h_size,
    input  logic [31:0]                   h_wdata,
    output logic [31:0]                   h_rdata,
    output logic                          h_ready,
    output logic                          h_err,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [$clog2(MEM_BYTES)-1:0]  mem_addr,
    output logic [3:0]                    mem_be,
    output logic [31:0]                   mem_wdata,
    input  logic [31:0]                   mem_rdata,
    output logic                          reg_req,
    output logic                          reg_we,
    output logic [REG_AW-1:0]             reg_addr,
    output logic [31:0]                   reg_wdata,
    input  logic [31:0]                   reg_rdata
);
    localparam int MEM_AW = $clog2(MEM_BYTES);
    localparam logic [REG_AW-1:0] IDX_A = REG_AW'(IDX_ADDR);

    state_e              state_q, state_d;
    logic [31:0]         idx_q;
    logic                op_we_q;
    logic [1:0]          op_size_q;
    logic [1:0]          op_lane_q;
    logic [31:0]         op_wdata_q;
    logic [REG_AW-3:0]   op_rword_q;
    logic [MEM_AW-1:0]   op_maddr_q;

    cls_e                cls;
    logic [REG_AW-3:0]   dec_word;
    logic [1:0]          dec_lane;
    logic [MEM_AW-1:0]   dec_moff;
    logic [31:0]         lane_src;
    logic [31:0]         lane_rd;
    logic [31:0]         lane_wr;

    ixwin_decode #(
        .REG_AW   (REG_AW),
        .MEM_BYTES(MEM_BYTES),
        .IDX_ADDR (IDX_ADDR),
        .WIN_ADDR (WIN_ADDR)
    ) u_decode (
        .h_addr  (h_addr),
        .h_size  (h_size),
        .idx_q   (idx_q),
        .cls     (cls),
        .tgt_word(dec_word),
        .lane    (dec_lane),
        .mem_off (dec_moff)
    );

    assign lane_src = (state_q == ST_MEMACC) ? mem_rdata : reg_rdata;

    ixwin_lanes u_lanes (
        .size   (op_size_q),
        .lane   (op_lane_q),
        .word_in(lane_src),
        .wdata  (op_wdata_q),
        .rd_val (lane_rd),
        .wr_word(lane_wr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (h_valid) begin
                    if (cls == CL_WIN_MEM)                          state_d = ST_MEMACC;
                    else if (cls == CL_WIN_REG || cls == CL_DIRECT) state_d = ST_REGACC;
                end
            end
            ST_MEMACC: state_d = ST_IDLE;
            ST_REGACC: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // pointer and latched operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            op_we_q    <= 1'b0;
            op_size_q  <= '0;
            op_lane_q  <= '0;
            op_wdata_q <= '0;
            op_rword_q <= '0;
            op_maddr_q <= '0;
        end else if (state_q == ST_IDLE && h_valid) begin
            if (cls == CL_INDEX && h_write) idx_q <= {h_wdata[31:2], 2'b00};
            op_we_q    <= h_write;
            op_size_q  <= h_size;
            op_lane_q  <= dec_lane;
            op_wdata_q <= h_wdata;
            op_rword_q <= dec_word;
            op_maddr_q <= dec_moff;
        end
    end

    // byte enables for memory, lanes counted from 0
    for (genvar b = 0; b < 4; b++) begin : g_be
        assign mem_be[b] = mem_req && (3'(b) < szb(op_size_q));
    end

    assign mem_addr  = op_maddr_q;
    assign mem_wdata = op_wdata_q;
    assign reg_addr  = {op_rword_q, 2'b00};

    // outputs
    always_comb begin
        h_ready   = 1'b0;
        h_err     = 1'b0;
        h_rdata   = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (h_valid) begin
                    unique case (cls)
                        CL_INDEX: begin
                            h_ready = 1'b1;
                            h_rdata = idx_q;
                        end
                        CL_REFUSE: begin
                            h_ready = 1'b1;
                            h_err   = 1'b1;
                        end
                        CL_DROP: h_ready = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_MEMACC: begin
                mem_req = 1'b1;
                mem_we  = op_we_q;
                h_ready = 1'b1;
                h_rdata = lane_rd;
            end
            ST_REGACC: begin
                reg_req   = 1'b1;
                reg_we    = op_we_q;
                reg_wdata = lane_wr;
                h_ready   = 1'b1;
                h_rdata   = lane_rd;
            end
            default: ;
        endcase
    end

    AST_IDX_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ready && h_write && h_addr == IDX_A && state_q == ST_IDLE) |=> (idx_q[1:0] == 2'b00 && idx_q[31:2] == $past(h_wdata[31:2]))); // R1

    AST_MEM_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((33'(mem_addr) + 33'(szb(op_size_q))) <= 33'(MEM_BYTES))); // R4

    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        h_err |-> (h_ready && h_rdata == 32'd0 && !mem_req && !reg_req)); // R6

    AST_ONE_EXTRA_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || reg_req) |=> (!mem_req && !reg_req)); // R9

    AST_BYTE_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_req && op_size_q == 2'd0) |-> (((reg_wdata ^ reg_rdata) & ~(32'hFF << {op_lane_q, 3'b000})) == 32'd0)); // R7

    AST_FULL_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_req && op_size_q[1] && op_lane_q == 2'd0) |-> (reg_wdata == op_wdata_q)); // R8

endmodule

// File: tb/ixwin_bridge_tb_top.sv
module ixwin_bridge_tb_top;
    localparam int REG_AW    = 14;
    localparam int MEM_BYTES = 4096;
    localparam int MEM_AW    = $clog2(MEM_BYTES);
    localparam int RWORDS    = (1 << REG_AW) / 4;
    localparam int MWORDS    = MEM_BYTES / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              h_valid = 1'b0, h_write = 1'b0;
    logic [REG_AW-1:0] h_addr = '0;
    logic [1:0]        h_size = '0;
    logic [31:0]       h_wdata = '0;
    logic [31:0]       h_rdata;
    logic              h_ready, h_err;
    logic              mem_req, mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [3:0]        mem_be;
    logic [31:0]       mem_wdata, mem_rdata;
    logic              reg_req, reg_we;
    logic [REG_AW-1:0] reg_addr;
    logic [31:0]       reg_wdata, reg_rdata;

    ixwin_bridge #(.REG_AW(REG_AW), .MEM_BYTES(MEM_BYTES), .IDX_ADDR(0), .WIN_ADDR(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_size(h_size),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready), .h_err(h_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
        return (32'(i) * 32'h9E37_79B1) ^ salt;
    endfunction

    // target storage models
    logic [31:0] rf [RWORDS];
    logic [31:0] vm [MWORDS];
    assign reg_rdata = rf[reg_addr[REG_AW-1:2]];
    assign mem_rdata = vm[mem_addr[MEM_AW-1:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RWORDS; i++) rf[i] <= pat(i, 32'h5A5A_0000);
            for (int i = 0; i < MWORDS; i++) vm[i] <= pat(i, 32'h00C3_3C00);
        end else begin
            if (reg_req && reg_we) rf[reg_addr[REG_AW-1:2]] <= reg_wdata;
            if (mem_req && mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) vm[mem_addr[MEM_AW-1:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    // expected state
    logic [31:0] s_rf [RWORDS];
    logic [31:0] s_vm [MWORDS];
    logic [31:0] s_idx;
    int n_cmp = 0;
    int n_bad = 0;

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_store(input string tag);
        int diffs = 0;
        for (int i = 0; i < RWORDS; i++) if (rf[i] !== s_rf[i]) diffs++;
        for (int i = 0; i < MWORDS; i++) if (vm[i] !== s_vm[i]) diffs++;
        chk(tag, 32'(diffs), 32'd0);
    endtask

    function automatic logic [31:0] smask(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic access(input logic we, input logic [REG_AW-1:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er,
                          output int cyc);
        @(negedge clk);
        h_valid = 1'b1; h_write = we; h_addr = a; h_size = sz; h_wdata = wd;
        cyc = 0; rd = '0; er = 1'b0;
        forever begin
            #1;
            if (h_ready) begin
                rd = h_rdata;
                er = h_err;
                break;
            end
            if (cyc > 8) begin
                chk("R9 handshake never completed", 32'(cyc), 32'd1);
                break;
            end
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        h_valid = 1'b0; h_write = 1'b0;
    endtask

    // one host operation with independently computed expectation
    task automatic do_op(input logic we, input logic [REG_AW-1:0] a, input logic [1:0] sz,
                         input logic [31:0] wd);
        logic [31:0] rd, m, mm, old;
        logic        er;
        int          cyc, w, sh, kind;
        logic [REG_AW-1:0] t;
        m = smask(sz);
        t = a;
        if (a == '0) kind = 0;
        else if (a[REG_AW-1:2] == 1) begin
            if (s_idx[31]) kind = ({1'b0, s_idx[30:0]} <= 32'(MEM_BYTES - nbytes(sz))) ? 3 : 2;
            else if (s_idx > 32'd7) begin
                kind = 4;
                t = s_idx[REG_AW-1:0] + REG_AW'(a[1:0]);
            end else kind = 1;
        end else kind = 5;

        access(we, a, sz, wd, rd, er, cyc);

        case (kind)
            0: begin
                chk("R9 index cycles", 32'(cyc), 32'd0);
                chk("R1 index err", 32'(er), 32'd0);
                if (!we) chk("R1 index read", rd, s_idx);
                else s_idx = {wd[31:2], 2'b00};
            end
            1: begin
                chk("R6 refuse cycles", 32'(cyc), 32'd0);
                chk("R6 refuse err", 32'(er), 32'd1);
                chk("R6 refuse data", rd, 32'd0);
                if (we) chk_store("R6 refused write untouched");
            end
            2: begin
                chk("R4 drop cycles", 32'(cyc), 32'd0);
                chk("R4 drop err", 32'(er), 32'd0);
                chk("R4 drop data", rd, 32'd0);
                if (we) chk_store("R4 dropped write untouched");
            end
            3: begin
                w = int'(s_idx[MEM_AW-1:2]);
                chk("R9 mem cycles", 32'(cyc), 32'd1);
                chk("R3 mem err", 32'(er), 32'd0);
                if (!we) chk("R3 mem read", rd, s_vm[w] & m);
                else begin
                    s_vm[w] = (s_vm[w] & ~m) | (wd & m);
                    chk("R3 mem write", vm[w], s_vm[w]);
                end
            end
            default: begin
                w  = int'(t[REG_AW-1:2]);
                sh = 8 * int'(t[1:0]);
                chk("R9 reg cycles", 32'(cyc), 32'd1);
                chk((kind == 4) ? "R5 fwd err" : "R10 direct err", 32'(er), 32'd0);
                if (!we) chk((kind == 4) ? "R5 R7 fwd read" : "R10 R7 direct read",
                             rd, (s_rf[w] >> sh) & m);
                else begin
                    old = s_rf[w];
                    mm  = m << sh;
                    s_rf[w] = (old & ~mm) | ((wd << sh) & mm);
                    if (sz[1] && sh == 0) chk("R8 full word write", rf[w], wd);
                    else chk((kind == 4) ? "R5 R7 fwd write" : "R10 R7 direct write", rf[w], s_rf[w]);
                end
            end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int seed;
        logic [31:0] v;
        seed = int'($urandom(32'h00C0_FFEE));
        for (int i = 0; i < RWORDS; i++) s_rf[i] = pat(i, 32'h5A5A_0000);
        for (int i = 0; i < MWORDS; i++) s_vm[i] = pat(i, 32'h00C3_3C00);
        s_idx = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R11 ready after reset", 32'(h_ready), 32'd0);
        chk("R11 mem_req after reset", 32'(mem_req), 32'd0);
        chk("R11 reg_req after reset", 32'(reg_req), 32'd0);
        chk("R11 err after reset", 32'(h_err), 32'd0);
        do_op(1'b0, 14'd0, 2'd2, 32'd0);            // R11 pointer reads 0
        do_op(1'b0, 14'd5, 2'd0, 32'd0);            // R11 window refused after reset

        // R1 low bits cleared
        do_op(1'b1, 14'd0, 2'd0, 32'h0000_1237);
        do_op(1'b0, 14'd0, 2'd2, 32'd0);
        // R6 boundary: pointer 4 and 7 refused
        do_op(1'b1, 14'd0, 2'd2, 32'd7);
        do_op(1'b1, 14'd6, 2'd2, 32'hDEAD_BEEF);
        // R5 boundary: pointer 8 forwards, offset 3 -> register byte 11
        do_op(1'b1, 14'd0, 2'd2, 32'd8);
        do_op(1'b0, 14'd7, 2'd0, 32'd0);
        do_op(1'b1, 14'd7, 2'd0, 32'h0000_00A5);
        do_op(1'b1, 14'd4, 2'd2, 32'h1234_5678);    // R8
        do_op(1'b1, 14'd6, 2'd1, 32'h0000_BEEF);    // R7 half at lane 2
        do_op(1'b0, 14'd4, 2'd3, 32'd0);
        // R3 memory, little-endian byte write
        do_op(1'b1, 14'd0, 2'd2, 32'h8000_0040);
        do_op(1'b1, 14'd4, 2'd0, 32'hFFFF_FFAB);
        do_op(1'b0, 14'd4, 2'd2, 32'd0);
        // R2 offset ignored for memory
        do_op(1'b0, 14'd6, 2'd1, 32'd0);
        do_op(1'b1, 14'd7, 2'd1, 32'h0000_C0DE);
        // R4 last legal word, first illegal address
        do_op(1'b1, 14'd0, 2'd2, 32'h8000_0000 | 32'(MEM_BYTES - 4));
        do_op(1'b1, 14'd4, 2'd2, 32'hCAFE_F00D);
        do_op(1'b0, 14'd4, 2'd2, 32'd0);
        do_op(1'b1, 14'd0, 2'd2, 32'h8000_0000 | 32'(MEM_BYTES));
        do_op(1'b1, 14'd4, 2'd0, 32'h0000_0011);
        do_op(1'b0, 14'd4, 2'd2, 32'd0);
        // R10 direct access, including addresses 1..3
        do_op(1'b1, 14'd2, 2'd0, 32'h0000_0077);
        do_op(1'b1, 14'h0123, 2'd1, 32'h0000_9876);
        do_op(1'b0, 14'h0120, 2'd2, 32'd0);

        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom % 6);
            if (op == 0) begin
                case ($urandom % 4)
                    0: v = 32'h8000_0000 | (($urandom % 32'(MWORDS + 4)) * 4);
                    1: v = (($urandom % 32'(RWORDS - 2)) + 2) * 4;
                    2: v = $urandom % 8;
                    default: v = 32'h8000_0000 | $urandom;
                endcase
                do_op(1'b1, 14'd0, 2'($urandom), v | 32'($urandom % 4));
            end else if (op == 5) begin
                do_op(1'($urandom), 14'(8 + ($urandom % 32'(RWORDS * 4 - 8))), 2'($urandom), $urandom);
            end else begin
                do_op(1'($urandom), 14'(4 + ($urandom % 4)), 2'($urandom), $urandom);
            end
        end
        chk_store("R5 R3 final storage");
        report();
    end

endmodule